// File: doc/BRIEF.md
# Programmable D1 video timing generator

This block produces the raster timing and sample stream for an 8-bit D1-style video output. Four configuration inputs set the clocks per line, the active pixels per line, the lines per field and the number of vertical blanking lines at the top of each field. Each counter is 12 bits wide, so the raster does not have to follow a broadcast standard.

Every line carries two embedded timing reference codes. Each code is the four bytes FF, 00, 00 and a status word. The status word holds the field, vertical and horizontal flags and four protection bits. Two sync outputs are driven at the same time as the codes. A horizontal gate is high on active pixels of active lines. A vertical gate is high for the whole of every active line. The samples between the codes are blanking levels or a simple ramp test pattern.

The configuration is sampled into the counters only at a field boundary. A field therefore always consists of whole lines of one geometry.

Top module: `vid_timing_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `vid_data` becomes 0x10, and `hgate`, `vgate` and `field_id` become 0. Also at that edge, the configuration inputs are taken as the geometry of the first field.
- R2: Line position p counts 0 to `cfg_line_total`-1. The first output sample after reset is position 0 of line 0 of field 0. Positions 0 to 3 of each line carry the EAV code FF, 00, 00, status word with H=1.
- R3: Let A = `cfg_line_total` - `cfg_active_px`. The active pixels occupy positions A to `cfg_line_total`-1. Positions A-4 to A-1 carry the SAV code FF, 00, 00, status word with H=0.
- R4: The status word is {1, F, V, H, V^H, F^H, F^V, F^V^H}, listed from bit 7 down to bit 0.
- R5: Any position that is neither a code nor an active pixel carries 0x80 when p is even and 0x10 when p is odd.
- R6: Active pixel k is pixel p-A, counted from 0. With `cfg_test_pat`=0 it carries 0x80 for even k and 0x10 for odd k. With `cfg_test_pat`=1 it carries 0x10 + (k mod 128).
- R7: `hgate` is 1 exactly on active pixel positions of lines that are not vertical blanking lines. It is 0 everywhere else.
- R8: Lines 0 to `cfg_vblank_lines`-1 of a field have V=1 and `vgate`=0. All later lines of the field have V=0 and `vgate`=1 for the whole line.
- R9: F, and with it `field_id`, is 0 in the first field after reset. It toggles at position 0 of line 0 of each new field.
- R10: A change on the configuration inputs takes effect only at the first line of the next field. The field in progress keeps its geometry and test pattern selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_line_total | input | 12 | Clocks per line (at least active pixels + 8) |
| cfg_active_px | input | 12 | Active pixels per line (at least 1) |
| cfg_field_lines | input | 12 | Lines per field (at least 1) |
| cfg_vblank_lines | input | 12 | Vertical blanking lines at the top of a field |
| cfg_test_pat | input | 1 | 1 selects the ramp test pattern for active pixels |
| vid_data | output | 8 | Byte stream with embedded timing codes |
| hgate | output | 1 | High on active pixels of active lines |
| vgate | output | 1 | High during active lines |
| field_id | output | 1 | Current field flag F |

## Verification
Three directed geometries are tried first:
- One active pixel in one-line fields, where F toggles on every line.
- The minimum eight blanking clocks with every line in vertical blanking.
- A geometry with no blanking lines at all.

Random geometries then change the configuration in the middle of a field. A bench model that reloads only at field wraps separates a correct reload point (R10) from an early one. Both pattern selections are used. They distinguish the parity-based blanking fill from the ramp index, and the ramp index also shows whether the active start position A is placed correctly.

// File: rtl/vtg_pkg.sv
// Shared types for the video timing generator.
// Assumes one 12-bit width for all raster counters.
package vtg_pkg;
    localparam int VTG_CW = 12;

    typedef struct packed {
        logic [VTG_CW-1:0] total;
        logic [VTG_CW-1:0] active;
        logic [VTG_CW-1:0] lines;
        logic [VTG_CW-1:0] vblank;
        logic              pattern;
    } vtg_cfg_t;

    // Build the timing reference status byte, protection bits included.
    function automatic logic [7:0] vtg_status(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction
endpackage

// File: rtl/vtg_counters.sv
// Raster counters: position within the line, line within the field and the field flag.
// Holds the shadow geometry, which is reloaded from the configuration inputs
// only at the field wrap (and during reset).
// Assumes total >= 1 and lines >= 1.
module vtg_counters
    import vtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  vtg_cfg_t          cfg_in,
    output vtg_cfg_t          cfg_act,
    output logic [VTG_CW-1:0] pos,
    output logic [VTG_CW-1:0] line,
    output logic              field
);
    logic pos_last;
    logic line_last;

    assign pos_last  = (pos == cfg_act.total - 1'b1);
    assign line_last = (line == cfg_act.lines - 1'b1);

    // Advance the position, wrap lines and fields, and reload geometry at the field wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos     <= '0;
            line    <= '0;
            field   <= 1'b0;
            cfg_act <= cfg_in;
        end else if (pos_last) begin
            pos <= '0;
            if (line_last) begin
                line    <= '0;
                field   <= ~field;
                cfg_act <= cfg_in;
            end else begin
                line <= line + 1'b1;
            end
        end else begin
            pos <= pos + 1'b1;
        end
    end

    // R2
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos < cfg_act.total);

    // R9
    field_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (field != $past(field)) |-> (pos == '0 && line == '0));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_act != $past(cfg_act)) |-> (pos == '0 && line == '0));
endmodule

// File: rtl/vtg_fmt.sv
// Sample formatter: from the raster position it selects a code byte, a blanking
// level or an active sample, and drives the two gates. All outputs are registered.
// Assumes total >= active + 8, so both codes fit in the blanking interval.
module vtg_fmt
    import vtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  vtg_cfg_t          cfg_act,
    input  logic [VTG_CW-1:0] pos,
    input  logic [VTG_CW-1:0] line,
    input  logic              field,
    output logic [7:0]        vid_data,
    output logic              hgate,
    output logic              vgate,
    output logic              field_id
);
    localparam int CODE_LEN = 4;

    logic [VTG_CW-1:0] act_start;
    logic [VTG_CW-1:0] sav_start;
    logic [VTG_CW-1:0] act_idx;
    logic [1:0]        code_idx;
    logic              in_eav;
    logic              in_sav;
    logic              in_act;
    logic              vflag;
    logic [7:0]        code_byte;
    logic [7:0]        act_byte;
    logic [7:0]        next_data;

    assign act_start = cfg_act.total - cfg_act.active;
    assign sav_start = act_start - VTG_CW'(CODE_LEN);
    assign act_idx   = pos - act_start;
    assign in_eav    = (pos < VTG_CW'(CODE_LEN));
    assign in_sav    = (pos >= sav_start) && (pos < act_start);
    assign in_act    = (pos >= act_start);
    assign vflag     = (line < cfg_act.vblank);

    // Pick the byte within a four-byte timing reference code.
    always_comb begin
        code_idx = in_eav ? pos[1:0] : (pos[1:0] - sav_start[1:0]);
        case (code_idx)
            2'd0:    code_byte = 8'hFF;
            2'd3:    code_byte = vtg_status(field, vflag, in_eav);
            default: code_byte = 8'h00;
        endcase
    end

    // Active sample: blanking-like fill or ramp test pattern.
    always_comb begin
        if (cfg_act.pattern)
            act_byte = 8'h10 + {1'b0, act_idx[6:0]};
        else
            act_byte = act_idx[0] ? 8'h10 : 8'h80;
    end

    // Select the stream byte for the current position.
    always_comb begin
        if (in_eav || in_sav)
            next_data = code_byte;
        else if (in_act)
            next_data = act_byte;
        else
            next_data = pos[0] ? 8'h10 : 8'h80;
    end

    // Register the stream and the sync outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_data <= 8'h10;
            hgate    <= 1'b0;
            vgate    <= 1'b0;
            field_id <= 1'b0;
        end else begin
            vid_data <= next_data;
            hgate    <= in_act && !vflag;
            vgate    <= !vflag;
            field_id <= field;
        end
    end

    // R2
    ff_then_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_data == 8'hFF) |=> (vid_data == 8'h00));

    // R7
    hgate_in_vgate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hgate |-> vgate);

    // R9
    field_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (field_id != $past(field_id)) |-> (vid_data == 8'hFF));
endmodule

// File: rtl/vid_timing_gen.sv
// Programmable D1-style video timing generator top level.
// Packs the configuration inputs, then chains the raster counters and the formatter.
// Outputs lag the raster counters by one register stage.
module vid_timing_gen
    import vtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VTG_CW-1:0] cfg_line_total,
    input  logic [VTG_CW-1:0] cfg_active_px,
    input  logic [VTG_CW-1:0] cfg_field_lines,
    input  logic [VTG_CW-1:0] cfg_vblank_lines,
    input  logic              cfg_test_pat,
    output logic [7:0]        vid_data,
    output logic              hgate,
    output logic              vgate,
    output logic              field_id
);
    vtg_cfg_t          cfg_in;
    vtg_cfg_t          cfg_act;
    logic [VTG_CW-1:0] pos;
    logic [VTG_CW-1:0] line;
    logic              field;

    assign cfg_in = '{total: cfg_line_total, active: cfg_active_px,
                      lines: cfg_field_lines, vblank: cfg_vblank_lines,
                      pattern: cfg_test_pat};

    vtg_counters u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_in  (cfg_in),
        .cfg_act (cfg_act),
        .pos     (pos),
        .line    (line),
        .field   (field)
    );

    vtg_fmt u_fmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_act  (cfg_act),
        .pos      (pos),
        .line     (line),
        .field    (field),
        .vid_data (vid_data),
        .hgate    (hgate),
        .vgate    (vgate),
        .field_id (field_id)
    );
endmodule

// File: tb/sim_vid_timing_gen.sv
// Bench: directed and seeded-random geometries checked sample by sample
// against a model built from the requirements.
module sim_vid_timing_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cfg_line_total = 12'd20;
    logic [11:0] cfg_active_px = 12'd8;
    logic [11:0] cfg_field_lines = 12'd3;
    logic [11:0] cfg_vblank_lines = 12'd1;
    logic        cfg_test_pat = 1'b0;
    logic [7:0]  vid_data;
    logic        hgate;
    logic        vgate;
    logic        field_id;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int m_pos, m_line, m_fields;
    bit m_f;
    int m_tot, m_act, m_lines, m_vb;
    bit m_pat;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_timing_gen u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_line_total(cfg_line_total), .cfg_active_px(cfg_active_px),
        .cfg_field_lines(cfg_field_lines), .cfg_vblank_lines(cfg_vblank_lines),
        .cfg_test_pat(cfg_test_pat),
        .vid_data(vid_data), .hgate(hgate), .vgate(vgate), .field_id(field_id)
    );

    function automatic logic [7:0] stat_word(bit f, bit v, bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic bit pending_cfg();
        return (m_tot != int'(cfg_line_total)) || (m_act != int'(cfg_active_px)) ||
               (m_lines != int'(cfg_field_lines)) || (m_vb != int'(cfg_vblank_lines)) ||
               (m_pat != cfg_test_pat);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: pos %0d line %0d actual 0x%0h expected 0x%0h",
                     tag, m_pos, m_line, act, exp);
        end
    endtask

    // Compare one output sample with the model, then advance the model.
    task automatic step();
        int a;
        bit v;
        int exp_d;
        int k;
        string tag;
        @(negedge clk);
        a = m_tot - m_act;
        v = (m_line < m_vb);
        if (m_pos < 4) begin
            tag = (m_pos == 3) ? "R4" : "R2";
            exp_d = (m_pos == 0) ? 32'hFF : (m_pos == 3) ? int'(stat_word(m_f, v, 1'b1)) : 0;
        end else if (m_pos >= a - 4 && m_pos < a) begin
            k = m_pos - (a - 4);
            tag = (k == 3) ? "R4" : "R3";
            exp_d = (k == 0) ? 32'hFF : (k == 3) ? int'(stat_word(m_f, v, 1'b0)) : 0;
        end else if (m_pos >= a) begin
            k = m_pos - a;
            tag = "R6";
            exp_d = m_pat ? (32'h10 + (k % 128)) : ((k % 2) ? 32'h10 : 32'h80);
        end else begin
            tag = "R5";
            exp_d = (m_pos % 2) ? 32'h10 : 32'h80;
        end
        if (pending_cfg()) tag = {tag, "/R10"};
        check(tag, int'(vid_data), exp_d);
        check("R7 hgate", int'(hgate), int'(m_pos >= a && !v));
        check("R8 vgate", int'(vgate), int'(!v));
        check("R9 field", int'(field_id), int'(m_f));
        // advance; geometry reload uses the inputs seen at the edge just passed
        if (m_pos == m_tot - 1) begin
            m_pos = 0;
            if (m_line == m_lines - 1) begin
                m_line = 0;
                m_f = !m_f;
                m_fields++;
                m_tot = int'(cfg_line_total); m_act = int'(cfg_active_px);
                m_lines = int'(cfg_field_lines); m_vb = int'(cfg_vblank_lines);
                m_pat = cfg_test_pat;
            end else begin
                m_line++;
            end
        end else begin
            m_pos++;
        end
    endtask

    task automatic set_cfg(int tot, int act, int lines, int vb, bit pat);
        cfg_line_total = 12'(tot); cfg_active_px = 12'(act);
        cfg_field_lines = 12'(lines); cfg_vblank_lines = 12'(vb);
        cfg_test_pat = pat;
    endtask

    // Run until the model reaches a mid-field point, apply a new geometry,
    // then run three more fields.
    task automatic run_cfg(int tot, int act, int lines, int vb, bit pat);
        int target;
        while (!(m_pos == m_tot / 2)) step();
        set_cfg(tot, act, lines, vb, pat);
        target = m_fields + 3;
        while (m_fields < target) step();
    endtask

    initial begin
        void'($urandom(32'd4242));
        set_cfg(20, 8, 3, 1, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 data", int'(vid_data), 32'h10);
        check("R1 hgate", int'(hgate), 0);
        check("R1 vgate", int'(vgate), 0);
        check("R1 field", int'(field_id), 0);
        m_pos = 0; m_line = 0; m_f = 0; m_fields = 0;
        m_tot = 20; m_act = 8; m_lines = 3; m_vb = 1; m_pat = 0;
        rst_n = 1'b1;
        // R2 first sample after reset is position 0 of line 0
        // directed corners: one pixel, one-line fields (F toggles every line)
        run_cfg(9, 1, 1, 0, 1'b1);
        // minimum blanking, all lines vertical blanking
        run_cfg(20, 12, 3, 3, 1'b0);
        // no blanking lines, long ramp beyond 128 pixels
        run_cfg(150, 140, 2, 0, 1'b1);
        for (int i = 0; i < 12; i++) begin
            int act, tot, lines, vb;
            act   = 1 + int'($urandom % 40);
            tot   = act + 8 + int'($urandom % 20);
            lines = 1 + int'($urandom % 8);
            vb    = int'($urandom % (lines + 1));
            run_cfg(tot, act, lines, vb, 1'($urandom % 2));
        end
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule